// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches 32 input pins and raises one interrupt line when any of them shows a condition that software has armed. Each pin has a private control word that picks how it is watched: not at all, while it is low, while it is high, on a rising transition, on a falling transition, or on any transition. Each incoming level first passes through a two-stage synchronizer. A detected condition then sets that pin's bit in a shared status word.

Software reads the status word to find out which pins fired. It clears bits by writing ones to them. The interrupt output stays asserted while any status bit is set. Access uses a simple single-cycle register bus with separate read and write strobes and a byte address. Read data is registered.

Top module: `gpio_irq_unit`

## Requirements
- R1: Pin n's control word sits at byte address 4·n (n = 0..31). Only its mode field, bits 19:16, is stored. A read returns that field in place and zero in every other bit.
- R2: Mode code 0x8 sets the pin's flag while the synchronized level is 0.
- R3: Mode code 0xC sets the pin's flag while the synchronized level is 1.
- R4: Mode code 0x9 sets the pin's flag on a 0-to-1 transition and ignores 1-to-0.
- R5: Mode code 0xA sets the pin's flag on a 1-to-0 transition and ignores 0-to-1.
- R6: Mode code 0xB sets the pin's flag on a transition in either direction.
- R7: Code 0x0, and any code other than 0x8, 0x9, 0xA, 0xB or 0xC, detects nothing. Writing 0 to a control word masks that pin.
- R8: The status word sits at byte address 0xA0, with bit n holding pin n's flag. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R9: When a new detection and a clear hit the same bit in the same cycle, the flag stays set. In a level mode the flag therefore stays set while the level persists.
- R10: `irq_o` is high exactly when at least one status bit is set.
- R11: Reset clears every control word and every flag, and drives `irq_o` low.
- R12: A pin change driven before clock edge N shows up in the flag and on `irq_o` just after edge N+2, and not earlier.
- R13: `bus_rdata` is updated on the edge where `bus_rd` is sampled high. Addresses that map to no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pins_i | input | 32 | Asynchronous pin levels |
| irq_o | output | 1 | Active-high interrupt, OR of all flags |

## Verification
A pin change driven between edges must not be visible after edges N or N+1. It must be visible just after edge N+2: one edge for each synchronizer stage, and the flag register captures at the second. The bench samples `irq_o` at the falling edge after each of these three rising edges.

Register writes take effect at the edge that samples them. Read data is sampled at the falling edge after the read edge. The pattern loop waits four cycles after each pin change before reading the status word, which is well past the three-edge latency.

For the case where an event and a clear coincide, the clear is placed on edge N+2 itself. The status word is read back afterwards.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned PIN_COUNT     = 32;
    localparam int unsigned BUS_DATA_W    = 32;
    localparam int unsigned BUS_ADDR_W    = 8;
    localparam int unsigned MODE_W        = 4;
    localparam int unsigned MODE_LSB      = 16;
    localparam int unsigned STATUS_ADDR   = 'hA0;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF  = 4'h0,
        MODE_LOW  = 4'h8,
        MODE_RISE = 4'h9,
        MODE_FALL = 4'hA,
        MODE_BOTH = 4'hB,
        MODE_HIGH = 4'hC
    } det_mode_e;

    function automatic logic mode_is_armed(input logic [MODE_W-1:0] m);
        return (m == MODE_LOW) || (m == MODE_RISE) || (m == MODE_FALL) ||
               (m == MODE_BOTH) || (m == MODE_HIGH);
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pins_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.sync;
    assign prev_o = st_q.prev;

    // R12: the history stage lags the synchronized level by exactly one cycle
    assert_prev_lags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_o == $past(sync_o)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              level_i,
    input  logic              last_i,
    output logic              event_o
);

    always_comb begin
        unique case (mode_i)
            MODE_LOW:  event_o = ~level_i;
            MODE_HIGH: event_o = level_i;
            MODE_RISE: event_o = level_i & ~last_i;
            MODE_FALL: event_o = ~level_i & last_i;
            MODE_BOTH: event_o = level_i ^ last_i;
            default:   event_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS    = PIN_COUNT,
    parameter int unsigned ADDR_W   = BUS_ADDR_W,
    parameter int unsigned DATA_W   = BUS_DATA_W,
    parameter int unsigned FIELD_LO = MODE_LSB,
    parameter int unsigned STAT_OFS = STATUS_ADDR
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic                         rd_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    input  logic [NPINS-1:0]             event_i,
    output logic [NPINS-1:0][MODE_W-1:0] mode_o,
    output logic [NPINS-1:0]             flags_o,
    output logic [DATA_W-1:0]            rdata_o
);

    localparam int unsigned IDX_W     = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam int unsigned CTRL_SPAN = NPINS * 4;

    typedef struct packed {
        logic [NPINS-1:0][MODE_W-1:0] mode;
        logic [NPINS-1:0]             flags;
        logic [DATA_W-1:0]            rdata;
    } regs_t;

    regs_t rg_d, rg_q;

    logic             ctrl_hit;
    logic             stat_hit;
    logic [IDX_W-1:0] ctrl_idx;
    logic [NPINS-1:0] clr_mask;

    always_comb begin
        ctrl_hit = (int'(addr_i) < int'(CTRL_SPAN)) && (addr_i[1:0] == 2'b00);
        stat_hit = (int'(addr_i) == int'(STAT_OFS));
        ctrl_idx = addr_i[IDX_W+1:2];
        clr_mask = (wr_i && stat_hit) ? wdata_i[NPINS-1:0] : '0;

        rg_d = rg_q;
        if (wr_i && ctrl_hit)
            rg_d.mode[ctrl_idx] = wdata_i[FIELD_LO +: MODE_W];

        // a detection in the same cycle overrides the clear
        rg_d.flags = (rg_q.flags & ~clr_mask) | event_i;

        if (rd_i) begin
            rg_d.rdata = '0;
            if (ctrl_hit)
                rg_d.rdata[FIELD_LO +: MODE_W] = rg_q.mode[ctrl_idx];
            else if (stat_hit)
                rg_d.rdata[NPINS-1:0] = rg_q.flags;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign mode_o  = rg_q.mode;
    assign flags_o = rg_q.flags;
    assign rdata_o = rg_q.rdata;

    // R8: a bit written with one and not hit by an event is clear afterwards
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && stat_hit) |=> ((flags_o & $past(clr_mask & ~event_i)) == '0));

    // R9: every detection leaves its flag set, whatever the bus did
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_i) |=> ((flags_o & $past(event_i)) == $past(event_i)));

    // R7: a flag never rises without a detection on that pin
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(event_i)) == '0));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS    = PIN_COUNT,
    parameter int unsigned ADDR_W   = BUS_ADDR_W,
    parameter int unsigned DATA_W   = BUS_DATA_W,
    parameter int unsigned FIELD_LO = MODE_LSB,
    parameter int unsigned STAT_OFS = STATUS_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pins_i,
    output logic              irq_o
);

    logic [NPINS-1:0]             level_w;
    logic [NPINS-1:0]             last_w;
    logic [NPINS-1:0]             event_w;
    logic [NPINS-1:0][MODE_W-1:0] mode_w;
    logic [NPINS-1:0]             flags_w;

    gpio_irq_sync #(.WIDTH(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .sync_o (level_w),
        .prev_o (last_w)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_irq_detect u_det (
            .mode_i  (mode_w[p]),
            .level_i (level_w[p]),
            .last_i  (last_w[p]),
            .event_o (event_w[p])
        );

        // R7: an unarmed pin never reports a detection
        assert_unarmed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_is_armed(mode_w[p]) |-> !event_w[p]);
    end

    gpio_irq_regs #(
        .NPINS    (NPINS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .FIELD_LO (FIELD_LO),
        .STAT_OFS (STAT_OFS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .event_i (event_w),
        .mode_o  (mode_w),
        .flags_o (flags_w),
        .rdata_o (bus_rdata)
    );

    assign irq_o = |flags_w;

endmodule

// File: tb/tb_gpio_irq_unit.sv
`timescale 1ns/1ps
module tb_gpio_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pins = '0;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins_i    (pins),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic [4:0] pin;
        logic [3:0] mode;
        logic       lvl0;
        logic       lvl1;
        logic       want;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  4'h9, 1'b0, 1'b1, 1'b1},   // R4 rise
        '{5'd5,  4'h9, 1'b1, 1'b0, 1'b0},   // R4 fall ignored
        '{5'd7,  4'hA, 1'b1, 1'b0, 1'b1},   // R5 fall
        '{5'd9,  4'hA, 1'b0, 1'b1, 1'b0},   // R5 rise ignored
        '{5'd12, 4'hB, 1'b0, 1'b1, 1'b1},   // R6
        '{5'd13, 4'hB, 1'b1, 1'b0, 1'b1},   // R6
        '{5'd20, 4'h8, 1'b1, 1'b0, 1'b1},   // R2
        '{5'd21, 4'h8, 1'b1, 1'b1, 1'b0},   // R2 high ignored
        '{5'd24, 4'hC, 1'b0, 1'b1, 1'b1},   // R3
        '{5'd25, 4'hC, 1'b0, 1'b0, 1'b0},   // R3 low ignored
        '{5'd31, 4'h0, 1'b0, 1'b1, 1'b0},   // R7 off
        '{5'd30, 4'h1, 1'b0, 1'b1, 1'b0},   // R7 unassigned
        '{5'd3,  4'hD, 1'b1, 1'b0, 1'b0},   // R7 unassigned
        '{5'd16, 4'h9, 1'b0, 1'b0, 1'b0}    // R4 no change
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R11 reset state
        bus_read(8'h00, rd);  check("R11 ctrl0 after reset", rd, 32'h0);
        bus_read(8'hA0, rd);  check("R11 status after reset", rd, 32'h0);
        check("R11 irq after reset", {31'b0, irq_o}, 32'h0);

        // R1 field storage, R13 unmapped address
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_read(8'h18, rd);  check("R1 ctrl readback", rd, 32'h000F_0000);
        bus_read(8'h9C, rd);  check("R13 unmapped reads zero", rd, 32'h0);
        bus_write(8'h18, 32'h0);

        // pattern table: R2..R7, R10
        for (int i = 0; i < NV; i++) begin
            pins[VECS[i].pin] = VECS[i].lvl0;
            idle(4);
            bus_write(8'(VECS[i].pin) << 2, {12'b0, VECS[i].mode, 16'b0});
            idle(2);
            bus_write(8'hA0, 32'hFFFF_FFFF);
            idle(2);
            pins[VECS[i].pin] = VECS[i].lvl1;
            idle(4);
            bus_read(8'hA0, rd);
            check($sformatf("R2-6/R7 vector %0d status", i), rd,
                  VECS[i].want ? (32'h1 << VECS[i].pin) : 32'h0);
            check($sformatf("R10 vector %0d irq", i), {31'b0, irq_o}, {31'b0, VECS[i].want});
            bus_write(8'(VECS[i].pin) << 2, 32'h0);
            pins = '0;
            idle(4);
            bus_write(8'hA0, 32'hFFFF_FFFF);
        end

        // R8: write zero keeps, write one clears only that bit
        bus_write(8'h00, 32'h0009_0000);
        bus_write(8'h30, 32'h0009_0000);
        pins[0] = 1'b1; pins[12] = 1'b1;
        idle(4);
        bus_write(8'hA0, 32'h0);
        bus_read(8'hA0, rd);  check("R8 write zero keeps", rd, 32'h0000_1001);
        bus_write(8'hA0, 32'h1);
        bus_read(8'hA0, rd);  check("R8 w1c one bit", rd, 32'h0000_1000);
        check("R10 irq with one flag", {31'b0, irq_o}, 32'h1);
        bus_write(8'hA0, 32'hFFFF_FFFF);
        bus_read(8'hA0, rd);  check("R8 clear all", rd, 32'h0);
        check("R10 irq low when clear", {31'b0, irq_o}, 32'h0);
        bus_write(8'h00, 32'h0);
        bus_write(8'h30, 32'h0);
        pins = '0;
        idle(4);
        bus_write(8'hA0, 32'hFFFF_FFFF);

        // R9 level persists through clear
        bus_write(8'h08, 32'h000C_0000);
        pins[2] = 1'b1;
        idle(4);
        bus_write(8'hA0, 32'h4);
        bus_read(8'hA0, rd);  check("R9 level reasserts", rd, 32'h4);
        pins[2] = 1'b0;
        idle(4);
        bus_write(8'hA0, 32'h4);
        bus_read(8'hA0, rd);  check("R9 clears once level gone", rd, 32'h0);
        bus_write(8'h08, 32'h0);

        // R12 latency on pin 8 rising
        bus_write(8'h20, 32'h0009_0000);
        @(negedge clk);
        pins[8] = 1'b1;
        @(negedge clk); check("R12 not after edge N", {31'b0, irq_o}, 32'h0);
        @(negedge clk); check("R12 not after edge N+1", {31'b0, irq_o}, 32'h0);
        @(negedge clk); check("R12 set after edge N+2", {31'b0, irq_o}, 32'h1);
        bus_write(8'h20, 32'h0);
        pins = '0;
        idle(4);
        bus_write(8'hA0, 32'hFFFF_FFFF);

        // R9 event and clear on the same edge
        bus_write(8'h10, 32'h0009_0000);
        @(negedge clk);
        pins[4] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'hA0; bus_wdata = 32'h10;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(8'hA0, rd);  check("R9 event beats clear", rd, 32'h10);
        bus_write(8'h10, 32'h0);
        pins = '0;

        // R11 reset mid-run
        bus_write(8'h04, 32'h000C_0000);
        pins[1] = 1'b1;
        idle(4);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        bus_read(8'h04, rd);  check("R11 ctrl cleared by reset", rd, 32'h0);
        bus_read(8'hA0, rd);  check("R11 flags cleared by reset", rd, 32'h0);
        check("R11 irq low after reset", {31'b0, irq_o}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule